// File: doc/BRIEF.md
# Two-wire bus register-pointer write slave

This block is the receive-side front end of a two-wire (I2C) slave that sits in front of a small register file and RAM. It oversamples the serial clock and data lines with the system clock and recognises START and STOP conditions. It matches a 7-bit device address and accepts only the write direction. The byte after the address is not stored: it loads an internal 8-bit word pointer. Every byte after that is presented on a one-cycle memory write port at the pointer, and the pointer then steps forward. The pointer wraps from the top location back to zero.

Acknowledge bits are produced by an open-drain enable, which pulls the data line low during the ninth clock of each accepted byte. A write-inhibit input from the supply monitor makes the slave withdraw from the bus. While it is high, no byte is acknowledged and no memory write is issued, and the slave stays silent until the next START. A repeated START or a STOP that arrives in the middle of a byte drops the partial byte.

Top module: `i2c_ptr_write_slave`

## Requirements
- R1: A falling data line while the clock line is high (START) begins address reception. A rising data line while the clock is high (STOP) returns the slave to idle with `sda_oe` low, and bytes clocked after a STOP are not acknowledged until a new START. After reset `sda_oe` and `mem_we` are low.
- R2: Data bits are sampled on rising clock-line edges, most significant bit first. In the address byte, bits 7..1 hold the device address and bit 0 is the direction. An address byte equal to {DEV_ADDR, 0} is acknowledged.
- R3: An address byte with another address, or with direction bit 1, is not acknowledged. The slave then ignores the bus until the next START.
- R4: The first byte after an accepted address is acknowledged and loads the word pointer. It issues no memory write.
- R5: Each later byte is acknowledged and produces exactly one single-cycle `mem_we` pulse. `mem_addr` carries the pointer and `mem_wdata` carries the byte. The pointer then increases by one. Any number of such bytes may follow before STOP.
- R6: The pointer is 8 bits wide, and a write at 0xFF is followed by a write at 0x00.
- R7: `sda_oe` rises after the falling clock edge that ends the eighth bit of an accepted byte. It stays high through the ninth clock's high phase and falls after that ninth clock's falling edge.
- R8: While `wr_inhibit` is high when a byte completes, that byte (address, pointer or data) is not acknowledged and not written. The slave then ignores later bytes until the next START.
- R9: A repeated START in the middle of a byte discards the partial byte without a write and restarts address reception.
- R10: A STOP in the middle of a data byte discards the partial byte without a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, many times faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| wr_inhibit | input | 1 | Supply-monitor write block; high withdraws the slave |
| sda_oe | output | 1 | Open-drain enable; high pulls the data line low |
| mem_we | output | 1 | Single-cycle memory write strobe |
| mem_addr | output | 8 | Memory write address (word pointer) |
| mem_wdata | output | 8 | Memory write data |

## Verification
The memory write and the pointer step happen at the same clock edge, so the pointer wrap and a write at the top location fall together. The bench provokes this by loading the pointer with 0xFE and streaming 256 bytes, then compares every logged write address with (0xFE + i) mod 256. The inhibit check and the acknowledge decision also share one edge. The bench raises `wr_inhibit` between two data bytes, so the next decision sees it, and requires a missing acknowledge, no logged write, and silence until a fresh START.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = 4;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ADDR,
    PH_PTR,
    PH_DATA
  } phase_t;

  // address byte: device address in bits 7..1, direction in bit 0 (0 = write)
  function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                    input logic [6:0] dev);
    return (b[7:1] == dev) && (b[0] == 1'b0);
  endfunction

  // word pointer advance, wrapping modulo 2**BYTE_W
  function automatic logic [BYTE_W-1:0] ptr_next(input logic [BYTE_W-1:0] p);
    return p + {{(BYTE_W-1){1'b0}}, 1'b1};
  endfunction

endpackage

// File: rtl/i2cw_line_sampler.sv
module i2cw_line_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det,
  output logic sda_bit
);

  logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
  logic scl_q, sda_q;
  logic scl_s, sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_sync[0] <= scl_in;
      sda_sync[0] <= sda_in;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        scl_sync[i] <= scl_sync[i-1];
        sda_sync[i] <= sda_sync[i-1];
      end
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_s = scl_sync[SYNC_STAGES-1];
  assign sda_s = sda_sync[SYNC_STAGES-1];

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  assign sda_bit   = sda_s;

endmodule

// File: rtl/i2cw_bit_shifter.sv
module i2cw_bit_shifter
  import i2cw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              sda_bit,
  output logic [BYTE_W-1:0] rx_byte,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              byte_end,
  output logic              ack_end
);

  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_CLK  = CNT_W'(BYTE_W + 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_byte <= '0;
      bit_cnt <= '0;
    end else if (start_det) begin
      bit_cnt <= '0;
    end else if (active) begin
      if (scl_rise && bit_cnt < LAST_BIT) begin
        rx_byte <= {rx_byte[BYTE_W-2:0], sda_bit};
        bit_cnt <= bit_cnt + 1'b1;
      end else if (scl_rise && bit_cnt == LAST_BIT) begin
        bit_cnt <= ACK_CLK;
      end else if (scl_fall && bit_cnt == ACK_CLK) begin
        bit_cnt <= '0;
      end
    end
  end

  // falling edge after the eighth data bit: acknowledge decision point
  assign byte_end = active & scl_fall & (bit_cnt == LAST_BIT);
  // falling edge of the ninth clock: end of acknowledge slot
  assign ack_end  = active & scl_fall & (bit_cnt == ACK_CLK);

  // R9: a START always restarts bit counting
  p_start_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (bit_cnt == '0));

endmodule

// File: rtl/i2cw_ctrl.sv
module i2cw_ctrl
  import i2cw_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h3C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              byte_end,
  input  logic              ack_end,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              wr_inhibit,
  output logic              busy,
  output logic              sda_oe,
  output logic              mem_we,
  output logic [BYTE_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata
);

  phase_t            phase;
  logic [BYTE_W-1:0] ptr_q;
  logic              accept;
  logic              take_addr, take_ptr, take_data;

  always_comb begin
    accept = 1'b0;
    if (!wr_inhibit) begin
      case (phase)
        PH_ADDR: accept = addr_hit(rx_byte, DEV_ADDR);
        PH_PTR,
        PH_DATA: accept = 1'b1;
        default: accept = 1'b0;
      endcase
    end
  end

  // named decision events, one per phase
  assign take_addr = byte_end & accept & (phase == PH_ADDR);
  assign take_ptr  = byte_end & accept & (phase == PH_PTR);
  assign take_data = byte_end & accept & (phase == PH_DATA);
  assign busy      = (phase != PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      ptr_q     <= '0;
      sda_oe    <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      if (start_det) begin
        phase  <= PH_ADDR;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        phase  <= PH_IDLE;
        sda_oe <= 1'b0;
      end else if (byte_end) begin
        if (!accept) begin
          phase <= PH_IDLE;
        end else begin
          sda_oe <= 1'b1;
          if (take_addr) phase <= PH_PTR;
          if (take_ptr) begin
            ptr_q <= rx_byte;
            phase <= PH_DATA;
          end
          if (take_data) begin
            mem_we    <= 1'b1;
            mem_addr  <= ptr_q;
            mem_wdata <= rx_byte;
            ptr_q     <= ptr_next(ptr_q);
          end
        end
      end else if (ack_end) begin
        sda_oe <= 1'b0;
      end
    end
  end

  // R1: STOP releases the line and idles the slave
  p_stop_idles_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!sda_oe && !busy));

  // R3: an idle slave never drives the line
  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sda_oe);

  // R4: pointer load takes the received byte and writes nothing
  p_ptr_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take_ptr |=> (ptr_q == $past(rx_byte)) && !mem_we);

  // R5: each write strobe lasts one cycle
  p_we_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  // R6: pointer sits one past the written address, modulo 256
  p_ptr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (ptr_q == ptr_next(mem_addr)));

  // R8: no write when the decision saw the inhibit
  p_inhibit_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !$past(wr_inhibit));

endmodule

// File: rtl/i2c_ptr_write_slave.sv
module i2c_ptr_write_slave
  import i2cw_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h3C,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic       wr_inhibit,
  output logic       sda_oe,
  output logic       mem_we,
  output logic [7:0] mem_addr,
  output logic [7:0] mem_wdata
);

  logic              scl_rise, scl_fall, start_det, stop_det, sda_bit;
  logic              busy, byte_end, ack_end;
  logic [BYTE_W-1:0] rx_byte;
  logic [CNT_W-1:0]  bit_cnt;

  i2cw_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_bit   (sda_bit)
  );

  i2cw_bit_shifter u_shifter (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (busy),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .sda_bit   (sda_bit),
    .rx_byte   (rx_byte),
    .bit_cnt   (bit_cnt),
    .byte_end  (byte_end),
    .ack_end   (ack_end)
  );

  i2cw_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .byte_end   (byte_end),
    .ack_end    (ack_end),
    .rx_byte    (rx_byte),
    .wr_inhibit (wr_inhibit),
    .busy       (busy),
    .sda_oe     (sda_oe),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata)
  );

  // R7: the line is only pulled low inside the acknowledge window
  p_oe_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (bit_cnt >= CNT_W'(BYTE_W)));

endmodule

// File: tb/sim_i2c_ptr_write_slave.sv
module sim_i2c_ptr_write_slave;

  localparam int         CLK_P  = 10;
  localparam int         Q      = 5;
  localparam int         WD_CYC = 190000;
  localparam logic [6:0] DEV    = 7'h3C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic inhib = 1'b0;
  logic sda_oe, mem_we;
  logic [7:0] mem_addr, mem_wdata;
  logic line;

  assign line = sda_m & ~sda_oe;

  always #(CLK_P/2) clk = ~clk;

  i2c_ptr_write_slave #(.DEV_ADDR(DEV)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(line),
    .wr_inhibit(inhib), .sda_oe(sda_oe), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [7:0] la [0:299];
  logic [7:0] ld [0:299];
  int nw = 0;

  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (nw < 300) begin
        la[nw] = mem_addr;
        ld[nw] = mem_wdata;
      end
      nw = nw + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; hq();
    scl = 1'b1; hq(); hq();
    scl = 1'b0; hq();
  endtask

  task automatic put_byte(input logic [7:0] b, output bit ack, output bit rel);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    sda_m = 1'b1; hq();
    scl = 1'b1; hq();
    ack = (line == 1'b0);
    hq();
    scl = 1'b0; hq();
    rel = !sda_oe;
  endtask

  task automatic start_c();
    sda_m = 1'b1; hq();
    scl = 1'b1; hq();
    sda_m = 1'b0; hq();
    scl = 1'b0; hq();
  endtask

  task automatic stop_c();
    sda_m = 1'b0; hq();
    scl = 1'b1; hq();
    sda_m = 1'b1; hq(); hq();
  endtask

  function automatic logic [7:0] dat(input int i);
    return 8'((i * 37 + 11) % 256);
  endfunction

  initial begin
    repeat (WD_CYC) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", WD_CYC, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    bit a, r;
    int nack_cnt, rel_bad;
    logic [7:0] aw;
    aw = {DEV, 1'b0};
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sda_oe == 1'b0, "R1 reset sda_oe", int'(sda_oe), 0);
    chk(mem_we == 1'b0, "R1 reset mem_we", int'(mem_we), 0);

    // R2 / R3: every address byte value
    nw = 0;
    for (int v = 0; v < 256; v++) begin
      logic [7:0] v8;
      bit exp;
      v8 = 8'(v);
      exp = (v / 2 == int'(DEV)) && (v % 2 == 0);
      start_c();
      put_byte(v8, a, r);
      stop_c();
      if (exp) chk(a == exp, "R2 address ack", int'(a), int'(exp));
      else     chk(a == exp, "R3 address nack", int'(a), int'(exp));
    end
    chk(nw == 0, "R3 no write in address sweep", nw, 0);

    // R4: pointer load only
    nw = 0;
    start_c();
    put_byte(aw, a, r);
    put_byte(8'h10, a, r);
    chk(a, "R4 pointer byte ack", int'(a), 1);
    chk(r, "R7 release after ninth clock", int'(r), 1);
    stop_c();
    chk(nw == 0, "R4 pointer load writes nothing", nw, 0);
    // R1: after STOP nothing is acknowledged without START
    put_byte(aw, a, r);
    chk(!a, "R1 no ack after stop", int'(a), 0);
    stop_c();

    // R5 / R6: 256-byte burst from 0xFE
    nw = 0; nack_cnt = 0; rel_bad = 0;
    start_c();
    put_byte(aw, a, r);
    put_byte(8'hFE, a, r);
    for (int i = 0; i < 256; i++) begin
      put_byte(dat(i), a, r);
      if (!a) nack_cnt++;
      if (!r) rel_bad++;
    end
    stop_c();
    chk(nack_cnt == 0, "R5 every data byte acked", nack_cnt, 0);
    chk(rel_bad == 0, "R7 release after each ack", rel_bad, 0);
    chk(nw == 256, "R5 write count", nw, 256);
    for (int i = 0; i < 256; i++) begin
      int ea;
      ea = (254 + i) % 256;
      if (ea < 2) chk(la[i] == 8'(ea), "R6 wrapped address", int'(la[i]), ea);
      else        chk(la[i] == 8'(ea), "R5 write address", int'(la[i]), ea);
      chk(ld[i] == dat(i), "R5 write data", int'(ld[i]), int'(dat(i)));
    end

    // R9: repeated START mid-byte
    nw = 0;
    start_c();
    put_byte(aw, a, r);
    put_byte(8'h40, a, r);
    put_byte(8'h11, a, r);
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
    start_c();
    put_byte(aw, a, r);
    chk(a, "R9 address acked after repeated start", int'(a), 1);
    put_byte(8'h50, a, r);
    put_byte(8'h22, a, r);
    stop_c();
    chk(nw == 2, "R9 write count", nw, 2);
    chk(la[0] == 8'h40 && ld[0] == 8'h11, "R9 first write", int'({la[0], ld[0]}), 16'h4011);
    chk(la[1] == 8'h50 && ld[1] == 8'h22, "R9 second write", int'({la[1], ld[1]}), 16'h5022);

    // R10: STOP mid-byte
    nw = 0;
    start_c();
    put_byte(aw, a, r);
    put_byte(8'h60, a, r);
    for (int i = 0; i < 5; i++) put_bit(1'b1);
    stop_c();
    chk(nw == 0, "R10 partial byte dropped", nw, 0);

    // R8: write inhibit
    nw = 0;
    inhib = 1'b1;
    start_c();
    put_byte(aw, a, r);
    chk(!a, "R8 address nack while inhibited", int'(a), 0);
    stop_c();
    inhib = 1'b0;
    start_c();
    put_byte(aw, a, r);
    put_byte(8'h70, a, r);
    put_byte(8'h33, a, r);
    chk(a, "R8 data acked before inhibit", int'(a), 1);
    inhib = 1'b1;
    put_byte(8'h44, a, r);
    chk(!a, "R8 data nack while inhibited", int'(a), 0);
    inhib = 1'b0;
    put_byte(8'h55, a, r);
    chk(!a, "R8 silent until START", int'(a), 0);
    start_c();
    put_byte(aw, a, r);
    put_byte(8'h71, a, r);
    put_byte(8'h66, a, r);
    stop_c();
    chk(nw == 2, "R8 write count", nw, 2);
    chk(la[0] == 8'h70 && ld[0] == 8'h33, "R8 first write", int'({la[0], ld[0]}), 16'h7033);
    chk(la[1] == 8'h71 && ld[1] == 8'h66, "R8 second write", int'({la[1], ld[1]}), 16'h7166);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule